// File: doc/BRIEF.md
# Indexed Dual-Bank Register RAM

This block lets a host reach two 128-byte banks through four byte-wide port offsets. There are two bank pairs, and each pair has an index port and a data port. The standard pair uses offsets 0 and 1. The extended pair uses offsets 2 and 3. The host writes a location number to an index port, then reads or writes the matching data port to move one byte to or from that location.

The standard bank is not all plain storage. Locations 0 through 13 belong to an external register file that holds time, alarm and control state. So do three more locations, whose addresses come from configuration inputs. Data-port accesses to any of these locations leave the block on a side interface. All other standard locations, and every extended location, are held in internal storage.

Each bank has its own lock input. While a bank's lock is high, reads of its data port return all ones and writes to its data port have no effect. Index ports are never locked.

Top module: `bankram_top`

## Requirements
- R1: After reset both index registers are 0 and busRdata is 0.
- R2: A write to offset 0 (or offset 2) loads bits 6:0 of busWdata into the standard (or extended) index, and bit 7 is dropped. A read of that offset returns the index with bit 7 cleared.
- R3: A read strobe sampled at a clock edge updates busRdata at that edge. busRdata keeps its value in every cycle that has no read strobe, writes included.
- R4: Standard-bank locations 0 to 13 are external. A data write at offset 1 raises regWr with regAddr set to the index and regWdata set to busWdata. A data read at offset 1 raises regRd, and busRdata then takes regRdata.
- R5: A standard index equal to any of the three 7-bit fields of ovlAddrs (field k at bits 7k+6:7k) is also routed to the external interface, exactly as in R4.
- R6: Any other standard location is internal storage. Data written at offset 1 reads back unchanged at offset 1, and the access raises neither regWr nor regRd.
- R7: The extended bank, reached through offsets 2 and 3, is internal at all 128 locations. Its accesses never raise regWr or regRd. The two banks stay independent at equal indices.
- R8: While stdLock is high, offset-1 reads return 0xFF and offset-1 writes change nothing, neither internal data nor the external interface. The extended bank keeps working.
- R9: While extLock is high, offset-3 reads return 0xFF and offset-3 writes change nothing. The standard bank keeps working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Port offset: 0 standard index, 1 standard data, 2 extended index, 3 extended data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| stdLock | input | 1 | Locks the standard data port |
| extLock | input | 1 | Locks the extended data port |
| ovlAddrs | input | 21 | Three 7-bit programmable external addresses |
| regAddr | output | 7 | Location number sent to the external register file |
| regWr | output | 1 | Write strobe to the external register file |
| regRd | output | 1 | Read strobe to the external register file |
| regWdata | output | 8 | Write data to the external register file |
| regRdata | input | 8 | Combinational read data from the external register file |

## Verification
The hardest case to reach is a locked write to a location that has no visible output. The write must be shown to have done nothing, and that is only possible after the lock is lifted. The bench first stores a known byte in an internal location. It then writes a different byte there while the lock is high, counts regWr pulses during the locked window, and reads the location back once the lock is released. The same bench covers external routing with a bench-side register model. That model is preloaded with distinct bytes, so that a read coming from the wrong source shows up as a mismatch.

// File: rtl/bankram_pkg.sv
package bankram_pkg;

  localparam logic [1:0] OFS_STD_IDX = 2'd0;
  localparam logic [1:0] OFS_STD_DAT = 2'd1;
  localparam logic [1:0] OFS_EXT_IDX = 2'd2;
  localparam logic [1:0] OFS_EXT_DAT = 2'd3;

  typedef enum logic [2:0] {
    RD_STD_IDX,
    RD_EXT_IDX,
    RD_STD_RAM,
    RD_EXT_RAM,
    RD_REG,
    RD_LOCKED
  } rdSrc_e;

  typedef struct packed {
    logic   stdIdxWr;
    logic   extIdxWr;
    logic   stdRamWr;
    logic   extRamWr;
    logic   regWr;
    logic   rdEn;
    rdSrc_e rdSrc;
  } bankStrobe_t;

endpackage

// File: rtl/bankram_ctrl.sv
module bankram_ctrl
  import bankram_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int NUM_FIXED = 14,
  parameter int NUM_OVL   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               busAddr,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic                     stdLock,
  input  logic                     extLock,
  input  logic [IDX_W-1:0]         stdIdx,
  input  logic [NUM_OVL*IDX_W-1:0] ovlAddrs,
  output bankStrobe_t              strobe,
  output logic                     regRd
);

  logic [NUM_OVL-1:0] ovlHit;
  logic               fixedHit;
  logic               isReg;

  // one comparator per programmable external location
  for (genvar g = 0; g < NUM_OVL; g++) begin : g_ovl
    assign ovlHit[g] = (stdIdx == ovlAddrs[g*IDX_W +: IDX_W]);
  end

  assign fixedHit = (stdIdx < IDX_W'(NUM_FIXED));
  assign isReg    = fixedHit | (|ovlHit);

  always_comb begin
    strobe       = '0;
    strobe.rdSrc = RD_STD_IDX;
    strobe.rdEn  = busRd;
    unique case (busAddr)
      OFS_STD_IDX: begin
        strobe.stdIdxWr = busWr;
        strobe.rdSrc    = RD_STD_IDX;
      end
      OFS_STD_DAT: begin
        if (stdLock) begin
          strobe.rdSrc = RD_LOCKED;
        end else if (isReg) begin
          strobe.regWr = busWr;
          strobe.rdSrc = RD_REG;
        end else begin
          strobe.stdRamWr = busWr;
          strobe.rdSrc    = RD_STD_RAM;
        end
      end
      OFS_EXT_IDX: begin
        strobe.extIdxWr = busWr;
        strobe.rdSrc    = RD_EXT_IDX;
      end
      default: begin
        if (extLock) begin
          strobe.rdSrc = RD_LOCKED;
        end else begin
          strobe.extRamWr = busWr;
          strobe.rdSrc    = RD_EXT_RAM;
        end
      end
    endcase
  end

  assign regRd = busRd && (busAddr == OFS_STD_DAT) && !stdLock && isReg;

  // a single access never writes more than one target
  p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.stdRamWr, strobe.extRamWr, strobe.regWr}));

  // the standard lock blocks every path into the standard bank
  p_std_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stdLock |-> !strobe.stdRamWr && !strobe.regWr && !regRd);

  // the extended lock blocks writes into the extended bank
  p_ext_lock_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    extLock |-> !strobe.extRamWr);

endmodule

// File: rtl/bankram_dp.sv
module bankram_dp
  import bankram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bankStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [IDX_W-1:0]  stdIdx,
  output logic [IDX_W-1:0]  extIdx
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int PAD_W = DATA_W - IDX_W;

  logic [DATA_W-1:0] stdMem [DEPTH];
  logic [DATA_W-1:0] extMem [DEPTH];
  logic [DATA_W-1:0] rdVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stdIdx <= '0;
      extIdx <= '0;
    end else begin
      if (strobe.stdIdxWr) stdIdx <= busWdata[IDX_W-1:0];
      if (strobe.extIdxWr) extIdx <= busWdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.stdRamWr) stdMem[stdIdx] <= busWdata;
    if (strobe.extRamWr) extMem[extIdx] <= busWdata;
  end

  always_comb begin
    unique case (strobe.rdSrc)
      RD_STD_IDX: rdVal = {{PAD_W{1'b0}}, stdIdx};
      RD_EXT_IDX: rdVal = {{PAD_W{1'b0}}, extIdx};
      RD_STD_RAM: rdVal = stdMem[stdIdx];
      RD_EXT_RAM: rdVal = extMem[extIdx];
      RD_REG:     rdVal = regRdata;
      default:    rdVal = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdVal;
  end

  // an index read never shows bits above the index width
  p_idx_msb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rdEn && (strobe.rdSrc == RD_STD_IDX || strobe.rdSrc == RD_EXT_IDX)
    |=> busRdata[DATA_W-1:IDX_W] == '0);

  // a write to one bank leaves the other bank's index alone
  p_idx_separate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stdIdxWr && !strobe.extIdxWr |=> $stable(extIdx));

endmodule

// File: rtl/bankram_top.sv
module bankram_top
  import bankram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 7,
  parameter int NUM_FIXED = 14,
  parameter int NUM_OVL   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               busAddr,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic                     stdLock,
  input  logic                     extLock,
  input  logic [NUM_OVL*IDX_W-1:0] ovlAddrs,
  output logic [IDX_W-1:0]         regAddr,
  output logic                     regWr,
  output logic                     regRd,
  output logic [DATA_W-1:0]        regWdata,
  input  logic [DATA_W-1:0]        regRdata
);

  bankStrobe_t      strobe;
  logic [IDX_W-1:0] stdIdx;
  logic [IDX_W-1:0] extIdx;

  bankram_ctrl #(
    .IDX_W(IDX_W), .NUM_FIXED(NUM_FIXED), .NUM_OVL(NUM_OVL)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .stdLock(stdLock), .extLock(extLock), .stdIdx(stdIdx), .ovlAddrs(ovlAddrs),
    .strobe(strobe), .regRd(regRd)
  );

  bankram_dp #(
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .busWdata(busWdata),
    .regRdata(regRdata), .busRdata(busRdata), .stdIdx(stdIdx), .extIdx(extIdx)
  );

  assign regAddr  = stdIdx;
  assign regWr    = strobe.regWr;
  assign regWdata = busWdata;

  p_std_lock_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busRd && busAddr == OFS_STD_DAT && stdLock |=> busRdata == '1);

  p_ext_lock_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busRd && busAddr == OFS_EXT_DAT && extLock |=> busRdata == '1);

  p_hold_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busRd |=> $stable(busRdata));

  p_ext_never_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr || regRd) |-> busAddr == OFS_STD_DAT);

endmodule

// File: tb/bankram_top_tb_top.sv
module bankram_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        stdLock = 1'b0;
  logic        extLock = 1'b0;
  logic [20:0] ovlAddrs;
  logic [6:0]  regAddr;
  logic        regWr;
  logic        regRd;
  logic [7:0]  regWdata;
  logic [7:0]  regRdata;

  logic [7:0]  extRegs [128];
  int          regWrCnt = 0;
  int          regRdCnt = 0;
  int          vectors = 0;
  int          miscompares = 0;
  logic [7:0]  rv;

  // programmable external locations: field0=0x32, field1=0x40, field2=0x7F
  assign ovlAddrs = {7'h7F, 7'h40, 7'h32};

  always #4 clk = ~clk;

  bankram_top dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .stdLock(stdLock), .extLock(extLock),
    .ovlAddrs(ovlAddrs), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  // model of the external register file
  assign regRdata = extRegs[regAddr];
  always @(posedge clk) begin
    if (regWr) begin
      extRegs[regAddr] <= regWdata;
      regWrCnt <= regWrCnt + 1;
    end
    if (regRd) regRdCnt <= regRdCnt + 1;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic testReset();
    check("R1 rdata after reset", busRdata, 8'h00);
    busRead(2'd0, rv); check("R1 std index reset", rv, 8'h00);
    busRead(2'd2, rv); check("R1 ext index reset", rv, 8'h00);
  endtask

  task automatic testIndex();
    busWrite(2'd0, 8'h95);
    busRead(2'd0, rv); check("R2 std index bit7 dropped", rv, 8'h15);
    busWrite(2'd2, 8'hC4);
    busRead(2'd2, rv); check("R2 ext index bit7 dropped", rv, 8'h44);
  endtask

  task automatic testInternal();
    int wc;
    wc = regWrCnt;
    busWrite(2'd0, 8'h20); busWrite(2'd1, 8'hA5);
    busWrite(2'd0, 8'h0E); busWrite(2'd1, 8'h11);
    busWrite(2'd0, 8'h7E); busWrite(2'd1, 8'h3C);
    busWrite(2'd0, 8'h20); busRead(2'd1, rv); check("R6 std loc 0x20", rv, 8'hA5);
    busWrite(2'd0, 8'h0E); busRead(2'd1, rv); check("R6 std loc 14", rv, 8'h11);
    busWrite(2'd0, 8'h7E); busRead(2'd1, rv); check("R6 std loc 0x7E", rv, 8'h3C);
    check("R6 no external writes", regWrCnt, wc);
  endtask

  task automatic testFixedReg();
    int wc;
    int rc;
    wc = regWrCnt; rc = regRdCnt;
    busWrite(2'd0, 8'h00); busWrite(2'd1, 8'h5A);
    check("R4 ext reg 0 written", extRegs[0], 8'h5A);
    check("R4 one regWr pulse", regWrCnt, wc + 1);
    extRegs[13] = 8'hC3;
    busWrite(2'd0, 8'h0D); busRead(2'd1, rv);
    check("R4 read loc 13 via regRdata", rv, 8'hC3);
    check("R4 one regRd pulse", regRdCnt, rc + 1);
  endtask

  task automatic testProgReg();
    extRegs[7'h7F] = 8'h6E;
    extRegs[7'h32] = 8'h81;
    busWrite(2'd0, 8'h40); busWrite(2'd1, 8'h77);
    check("R5 field1 location written", extRegs[7'h40], 8'h77);
    busWrite(2'd0, 8'h7F); busRead(2'd1, rv); check("R5 field2 location read", rv, 8'h6E);
    busWrite(2'd0, 8'h32); busRead(2'd1, rv); check("R5 field0 location read", rv, 8'h81);
  endtask

  task automatic testExtBank();
    int wc;
    int rc;
    wc = regWrCnt; rc = regRdCnt;
    extRegs[5] = 8'h00;
    busWrite(2'd2, 8'h05); busWrite(2'd3, 8'h99);
    busRead(2'd3, rv); check("R7 ext loc 5 readback", rv, 8'h99);
    check("R7 ext reg file untouched", extRegs[5], 8'h00);
    check("R7 no regWr from ext", regWrCnt, wc);
    check("R7 no regRd from ext", regRdCnt, rc);
    busWrite(2'd0, 8'h21); busWrite(2'd1, 8'h12);
    busWrite(2'd2, 8'h21); busWrite(2'd3, 8'h34);
    busRead(2'd1, rv); check("R7 std side at 0x21", rv, 8'h12);
    busRead(2'd3, rv); check("R7 ext side at 0x21", rv, 8'h34);
  endtask

  task automatic testStdLock();
    int wc;
    busWrite(2'd0, 8'h20);
    @(negedge clk); stdLock = 1'b1;
    wc = regWrCnt;
    busRead(2'd1, rv); check("R8 locked read gives FF", rv, 8'hFF);
    busWrite(2'd1, 8'h00);
    busWrite(2'd0, 8'h00); busWrite(2'd1, 8'hEE);
    check("R8 locked external write blocked", regWrCnt, wc);
    busRead(2'd3, rv); check("R8 ext bank still open", rv, 8'h34);
    busWrite(2'd0, 8'h20);
    @(negedge clk); stdLock = 1'b0;
    busRead(2'd1, rv); check("R8 data kept through lock", rv, 8'hA5);
    check("R8 ext reg 0 kept", extRegs[0], 8'h5A);
  endtask

  task automatic testExtLock();
    @(negedge clk); extLock = 1'b1;
    busRead(2'd3, rv); check("R9 locked read gives FF", rv, 8'hFF);
    busWrite(2'd3, 8'h01);
    busRead(2'd1, rv); check("R9 std bank still open", rv, 8'hA5);
    @(negedge clk); extLock = 1'b0;
    busRead(2'd3, rv); check("R9 data kept through lock", rv, 8'h34);
  endtask

  task automatic testHold();
    busRead(2'd3, rv);
    busWrite(2'd2, 8'h05);
    repeat (3) @(negedge clk);
    check("R3 rdata held across write and idle", busRdata, 8'h34);
    busRead(2'd3, rv); check("R3 new read updates", rv, 8'h99);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) extRegs[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testIndex();
    testInternal();
    testFixedReg();
    testProgReg();
    testExtBank();
    testStdLock();
    testExtLock();
    testHold();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

endmodule